// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block follows an Ethernet receive MAC and judges every incoming frame on two independent axes: its destination address and its end-of-frame status. Bytes arrive one per cycle with start and end strobes. The block captures the six destination-address bytes and builds a CRC-32 hash over them as they arrive. It also counts the frame length. It then decides whether the frame should be kept in the receive buffer and whether any host interrupt should be raised.

A frame is kept only when two conditions both hold. First, some enabled address class must match. Second, some enabled status class must hold. While the frame is streaming, a per-byte write enable tells the buffer which bytes to store. That enable drops after the largest legal frame size, so oversized frames arrive truncated. The verdict and the event pulses appear exactly one clock after the last byte.

Top module: `rx_frame_filter`

## Requirements
- R1: While reset is asserted and after its release until the first frame ends, `done`, `accept`, `wr_en` and all four interrupt outputs are 0.
- R2: When a byte with `in_valid` and `in_eof` set closes a frame, `done` is high for exactly the following clock cycle, and `accept` and the interrupt outputs are valid in that same cycle and low in every cycle where `done` is low.
- R3: With `accept_en[0]` (promiscuous) set, every destination address passes the address filter, including frames shorter than six bytes.
- R4: With `accept_en[3]` set, a destination address equal to `station_addr` passes. With `accept_en[4]` set, the all-ones address passes. The first received byte maps to bits 47:40 and the sixth to bits 7:0.
- R5: The hash index is bits 31:26 of a reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, no final inversion, each byte taken LSB first) over the six address bytes. A destination address passes when `hash_table[index]` is 1 and one of two conditions holds: `accept_en[1]` is set and bit 40 is 0 (individual address), or `accept_en[2]` is set and the address is multicast (bit 40 is 1 and the address is not all ones).
- R6: An address match alone never accepts a frame. With `accept_en[5]` set, a frame of 64 to 1518 bytes inclusive with `in_crc_ok` high on its last byte is accepted if its address passes. With that bit clear, such a frame is not accepted unless another enabled status class applies.
- R7: Status classes may overlap, and each has its own enable. `accept_en[6]` accepts frames with `in_crc_ok` low. `accept_en[7]` accepts frames shorter than 64 bytes. `accept_en[8]` accepts frames longer than 1518 bytes. In every case the address must pass. Lengths count every byte including the FCS.
- R8: `wr_en` is high in the same cycle as each of the first 1518 bytes of a frame and low for every later byte of that frame.
- R9: `irq_good`, `irq_crc`, `irq_runt` and `irq_long` pulse for their class when the corresponding `irq_en` bit (0, 1, 2, 3) is set and the address passes. This does not depend on the status-class accept enables.
- R10: Bytes presented with `in_valid` high outside a frame (after an end strobe and before the next start strobe) produce no `wr_en` and no `done`.
- R11: A frame that ends before its sixth byte fails every address class except promiscuous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte present on `in_data` |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Received byte |
| in_crc_ok | input | 1 | FCS check result, sampled with the last byte |
| station_addr | input | 48 | Programmed individual address |
| hash_table | input | 64 | Hash filter bits |
| accept_en | input | 9 | Address-class and status-class accept enables |
| irq_en | input | 4 | Event interrupt enables |
| wr_en | output | 1 | Store the current byte in the buffer |
| done | output | 1 | Frame verdict valid |
| accept | output | 1 | Frame is kept |
| irq_good | output | 1 | Good-frame event |
| irq_crc | output | 1 | Bad-CRC event |
| irq_runt | output | 1 | Short-frame event |
| irq_long | output | 1 | Oversize event |

## Verification
The bench targets the length boundaries at 63, 64, 1518 and 1519 bytes. A design with an off-by-one length comparison would misclassify runts or oversize frames, or write one byte too many or too few. Frames of one to five bytes check that a partial address never matches. A design that reads stale address bytes from the previous frame would accept them. Hash hits are forced by setting the single table bit the bench computes, and unicast and multicast hash enables are crossed. A design that mixed them up would accept through the wrong enable. Interrupts are exercised with the matching accept enable cleared, which exposes any design that ties events to acceptance. Stray bytes outside a frame show whether the design would write or report them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // accept enable bit positions
  localparam int AE_PROMISC  = 0;
  localparam int AE_UC_HASH  = 1;
  localparam int AE_MC_HASH  = 2;
  localparam int AE_EXACT    = 3;
  localparam int AE_BCAST    = 4;
  localparam int AE_CLS_LSB  = 5;
  localparam int NUM_CLASSES = 4;
  localparam int AE_W        = AE_CLS_LSB + NUM_CLASSES;

  // status class order, shared by accept enables and interrupt enables
  localparam int CLS_GOOD = 0;
  localparam int CLS_CRC  = 1;
  localparam int CLS_RUNT = 2;
  localparam int CLS_LONG = 3;

  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  // one byte of a reflected CRC-32, LSB of the byte first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] cur,
                                                input logic [7:0]  dat);
    logic [31:0] acc;
    acc = cur;
    for (int k = 0; k < 8; k++) begin
      if (acc[0] ^ dat[k]) acc = (acc >> 1) ^ CRC_POLY;
      else                 acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
  parameter int MAX_LEN = 1518,
  parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             byte_take,
  output logic             frame_end,
  output logic [LEN_W-1:0] byte_idx,
  output logic [LEN_W-1:0] len_cur,
  output logic             wr_en
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(MAX_LEN + 1);

  logic             in_frame_q, in_frame_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    byte_take = in_valid && (in_sof || in_frame_q);
    frame_end = byte_take && in_eof;
    byte_idx  = in_sof ? '0 : cnt_q;
    len_cur   = (byte_idx >= LEN_SAT) ? LEN_SAT : byte_idx + LEN_W'(1);
    wr_en     = byte_take && (byte_idx < LEN_MAX);
    cnt_en    = byte_take;
    cnt_d     = len_cur;
    in_frame_d = !in_eof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (cnt_en) begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
    end
  end

endmodule

// File: rtl/rxf_da_capture.sv
module rxf_da_capture
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int LEN_W      = 11,
  localparam int DA_W      = 8 * ADDR_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_take,
  input  logic [LEN_W-1:0]     byte_idx,
  input  logic [7:0]           in_data,
  output logic [DA_W-1:0]      da_nxt,
  output logic [HASH_BITS-1:0] hash_idx,
  output logic                 da_full
);

  logic [DA_W-1:0] da_q;
  logic [31:0]     crc_q, crc_nxt, crc_base;
  logic            addr_byte;

  // byte b of the address lands in the slot that keeps first byte on top
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_slot
    always_comb begin
      if (byte_take && byte_idx == LEN_W'(b))
        da_nxt[DA_W-1-8*b -: 8] = in_data;
      else
        da_nxt[DA_W-1-8*b -: 8] = da_q[DA_W-1-8*b -: 8];
    end
  end

  always_comb begin
    addr_byte = byte_take && (byte_idx < LEN_W'(ADDR_BYTES));
    crc_base  = (byte_idx == '0) ? CRC_SEED : crc_q;
    crc_nxt   = addr_byte ? crc_step_byte(crc_base, in_data) : crc_q;
    hash_idx  = crc_nxt[31 -: HASH_BITS];
    da_full   = byte_idx >= LEN_W'(ADDR_BYTES - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_q  <= '0;
      crc_q <= '0;
    end else if (byte_take) begin
      da_q  <= da_nxt;
      crc_q <= crc_nxt;
    end
  end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  parameter int LEN_W      = 11,
  localparam int DA_W      = 8 * ADDR_BYTES,
  localparam int HT_W      = 1 << HASH_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_end,
  input  logic                   da_full,
  input  logic [DA_W-1:0]        da_nxt,
  input  logic [HASH_BITS-1:0]   hash_idx,
  input  logic [LEN_W-1:0]       len_cur,
  input  logic                   crc_ok,
  input  logic [DA_W-1:0]        station_addr,
  input  logic [HT_W-1:0]        hash_table,
  input  logic [AE_W-1:0]        accept_en,
  input  logic [NUM_CLASSES-1:0] irq_en,
  output logic                   done,
  output logic                   accept,
  output logic [NUM_CLASSES-1:0] irq
);

  logic                   is_bcast, is_group, is_mcast, hash_hit, exact_hit;
  logic                   addr_pass;
  logic [NUM_CLASSES-1:0] cls, cls_en;
  logic                   done_d, accept_d;
  logic [NUM_CLASSES-1:0] irq_d;

  always_comb begin
    is_bcast  = &da_nxt;
    is_group  = da_nxt[DA_W-8];
    is_mcast  = is_group && !is_bcast;
    hash_hit  = hash_table[hash_idx];
    exact_hit = (da_nxt == station_addr);

    addr_pass = accept_en[AE_PROMISC] ||
                (da_full && ((accept_en[AE_EXACT]   && exact_hit) ||
                             (accept_en[AE_BCAST]   && is_bcast)  ||
                             (accept_en[AE_UC_HASH] && !is_group && hash_hit) ||
                             (accept_en[AE_MC_HASH] && is_mcast  && hash_hit)));

    cls[CLS_RUNT] = len_cur < LEN_W'(MIN_LEN);
    cls[CLS_LONG] = len_cur > LEN_W'(MAX_LEN);
    cls[CLS_CRC]  = !crc_ok;
    cls[CLS_GOOD] = crc_ok && !cls[CLS_RUNT] && !cls[CLS_LONG];
    cls_en        = accept_en[AE_CLS_LSB +: NUM_CLASSES];

    done_d   = frame_end;
    accept_d = frame_end && addr_pass && |(cls & cls_en);
    irq_d    = {NUM_CLASSES{frame_end && addr_pass}} & cls & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      accept <= 1'b0;
      irq    <= '0;
    end else begin
      done   <= done_d;
      accept <= accept_d;
      irq    <= irq_d;
    end
  end

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int MIN_LEN    = 64,
  parameter int MAX_LEN    = 1518,
  localparam int DA_W      = 8 * ADDR_BYTES,
  localparam int HT_W      = 1 << HASH_BITS,
  localparam int LEN_W     = $clog2(MAX_LEN + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic                   in_eof,
  input  logic [7:0]             in_data,
  input  logic                   in_crc_ok,
  input  logic [DA_W-1:0]        station_addr,
  input  logic [HT_W-1:0]        hash_table,
  input  logic [AE_W-1:0]        accept_en,
  input  logic [NUM_CLASSES-1:0] irq_en,
  output logic                   wr_en,
  output logic                   done,
  output logic                   accept,
  output logic                   irq_good,
  output logic                   irq_crc,
  output logic                   irq_runt,
  output logic                   irq_long
);

  logic                   byte_take, frame_end, da_full;
  logic [LEN_W-1:0]       byte_idx, len_cur;
  logic [DA_W-1:0]        da_nxt;
  logic [HASH_BITS-1:0]   hash_idx;
  logic [NUM_CLASSES-1:0] irq;

  rxf_len_track #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .byte_take(byte_take), .frame_end(frame_end),
    .byte_idx(byte_idx), .len_cur(len_cur), .wr_en(wr_en)
  );

  rxf_da_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS),
                   .LEN_W(LEN_W)) u_da (
    .clk(clk), .rst_n(rst_n), .byte_take(byte_take), .byte_idx(byte_idx),
    .in_data(in_data), .da_nxt(da_nxt), .hash_idx(hash_idx),
    .da_full(da_full)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS),
               .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .da_full(da_full),
    .da_nxt(da_nxt), .hash_idx(hash_idx), .len_cur(len_cur),
    .crc_ok(in_crc_ok), .station_addr(station_addr),
    .hash_table(hash_table), .accept_en(accept_en), .irq_en(irq_en),
    .done(done), .accept(accept), .irq(irq)
  );

  assign irq_good = irq[CLS_GOOD];
  assign irq_crc  = irq[CLS_CRC];
  assign irq_runt = irq[CLS_RUNT];
  assign irq_long = irq[CLS_LONG];

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int MAX_LEN = 1518
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_eof,
  input logic [3:0] class_en,
  input logic       wr_en,
  input logic       done,
  input logic       accept,
  input logic       irq_good,
  input logic       irq_crc,
  input logic       irq_runt,
  input logic       irq_long
);

  localparam int CW = $clog2(MAX_LEN + 2);

  logic [CW-1:0] wcount;
  logic [CW-1:0] wbase;

  assign wbase = in_sof ? '0 : wcount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wcount <= '0;
    else if (wr_en) wcount <= wbase + CW'(1);
    else if (in_valid && in_sof) wcount <= '0;
  end

  a_r2_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_eof));

  a_r2_accept_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> done);

  a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_good || irq_crc || irq_runt || irq_long) |-> done);

  a_r7_good_excludes_others: assert property (@(posedge clk) disable iff (!rst_n)
    irq_good |-> !(irq_crc || irq_runt || irq_long));

  a_r6_accept_needs_class: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (class_en != 4'b0000));

  a_r10_wr_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> in_valid);

  a_r8_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wbase < CW'(MAX_LEN)));

endmodule

bind rx_frame_filter rxf_checker #(.MAX_LEN(MAX_LEN)) u_rxf_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .class_en(accept_en[8:5]), .wr_en(wr_en), .done(done),
  .accept(accept), .irq_good(irq_good), .irq_crc(irq_crc),
  .irq_runt(irq_runt), .irq_long(irq_long)
);

// File: tb/rx_frame_filter_bench.sv
module rx_frame_filter_bench;

  localparam int CLK_P   = 10;
  localparam int MAXL    = 1518;
  localparam int MINL    = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, in_crc_ok;
  logic [7:0]  in_data;
  logic [47:0] station_addr;
  logic [63:0] hash_table;
  logic [8:0]  accept_en;
  logic [3:0]  irq_en;
  logic        wr_en, done, accept, irq_good, irq_crc, irq_runt, irq_long;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_frame_filter u_rx_frame_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_crc_ok(in_crc_ok),
    .station_addr(station_addr), .hash_table(hash_table),
    .accept_en(accept_en), .irq_en(irq_en), .wr_en(wr_en), .done(done),
    .accept(accept), .irq_good(irq_good), .irq_crc(irq_crc),
    .irq_runt(irq_runt), .irq_long(irq_long)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] da);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ da[40 - 8*k + j];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c[31:26];
  endfunction

  function automatic bit ref_addr(input logic [47:0] da, input int len);
    bit grp, bc, hit;
    if (accept_en[0]) return 1;                      // R3
    if (len < 6) return 0;                           // R11
    bc  = (da == 48'hFFFF_FFFF_FFFF);
    grp = da[40];
    hit = hash_table[ref_hash(da)];
    if (accept_en[3] && da == station_addr) return 1; // R4
    if (accept_en[4] && bc) return 1;
    if (accept_en[1] && !grp && hit) return 1;        // R5
    if (accept_en[2] && grp && !bc && hit) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] ref_cls(input int len, input bit ok);
    logic [3:0] c;
    c[2] = len < MINL;
    c[3] = len > MAXL;
    c[1] = !ok;
    c[0] = ok && !c[2] && !c[3];
    return c;
  endfunction

  task automatic send_frame(input int len, input logic [47:0] da,
                            input bit ok, input string tag);
    int   wc;
    bit   ap;
    logic [3:0] cl, exp_irq;
    wc = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sof    = (i == 0);
      in_eof    = (i == len - 1);
      in_crc_ok = ok;
      in_data   = (i < 6) ? da[47 - 8*i -: 8] : 8'($urandom);
      #1;
      if (wr_en) wc++;
      if (i > 0 && i < len) check({tag, " R2 no done mid-frame"}, int'(done), 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    #1;
    ap      = ref_addr(da, len);
    cl      = ref_cls(len, ok);
    exp_irq = ap ? (cl & irq_en) : 4'b0;
    check({tag, " R8 bytes written"}, wc, (len < MAXL) ? len : MAXL);
    check({tag, " R2 done"}, int'(done), 1);
    check({tag, " R6 R7 accept"}, int'(accept), int'(ap && |(cl & accept_en[8:5])));
    check({tag, " R9 irq"}, int'({irq_long, irq_runt, irq_crc, irq_good}), int'(exp_irq));
    @(negedge clk);
    #1;
    check({tag, " R2 done single cycle"}, int'(done), 0);
  endtask

  task automatic stray_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == n - 1);
      in_data  = 8'($urandom);
      #1;
      check("R10 stray byte wr_en", int'(wr_en), 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    #1;
    check("R10 stray bytes no done", int'(done), 0);
  endtask

  function automatic int pick_len();
    case ($urandom % 10)
      0: return 1 + int'($urandom % 5);
      1: return 63;
      2: return 64;
      3: return 65;
      4: return MAXL;
      5: return MAXL + 1;
      6: return MAXL + 1 + int'($urandom % 12);
      default: return 64 + int'($urandom % 200);
    endcase
  endfunction

  function automatic logic [47:0] pick_da();
    logic [47:0] r;
    r = {16'($urandom), 32'($urandom)};
    case ($urandom % 5)
      0: return station_addr;
      1: return 48'hFFFF_FFFF_FFFF;
      2: return {r[47:41], 1'b1, r[39:0]};
      3: return {r[47:41], 1'b0, r[39:0]};
      default: return station_addr ^ 48'h1;
    endcase
  endfunction

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [47:0] mc;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0; in_crc_ok = 0;
    station_addr = 48'h02_11_22_33_44_55;
    hash_table   = '0;
    accept_en    = '0;
    irq_en       = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset done",   int'(done), 0);
    check("R1 reset accept", int'(accept), 0);
    check("R1 reset irq", int'({irq_long, irq_runt, irq_crc, irq_good}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after release done", int'(done), 0);
    check("R1 after release wr_en", int'(wr_en), 0);

    // exact match, good frame (R4, R6)
    accept_en = 9'b0_0010_1000; irq_en = 4'b1111;
    send_frame(100, station_addr, 1, "exact good");
    // good enable cleared: not accepted, interrupt still fires (R6, R9)
    accept_en = 9'b1_1100_1000;
    send_frame(100, station_addr, 1, "good disabled");
    // broadcast (R4)
    accept_en = 9'b0_0011_0000;
    send_frame(64, 48'hFFFF_FFFF_FFFF, 1, "bcast 64");
    send_frame(63, 48'hFFFF_FFFF_FFFF, 1, "bcast runt");
    // oversize truncation (R8, R7)
    accept_en = 9'b1_0001_0000;
    send_frame(1530, 48'hFFFF_FFFF_FFFF, 1, "long trunc");
    send_frame(MAXL, 48'hFFFF_FFFF_FFFF, 1, "max length");
    // short frames: promiscuous versus exact (R3, R11)
    accept_en = 9'b0_1000_1000;
    send_frame(5, station_addr, 1, "R11 short exact");
    accept_en = 9'b0_1000_0001;
    send_frame(3, 48'h0, 0, "R3 short promisc");
    // stray bytes (R10)
    stray_bytes(4);
    // multicast hash hit (R5)
    mc = 48'h01_00_5E_12_34_56;
    hash_table = 64'h1 << ref_hash(mc);
    accept_en = 9'b0_0010_0100;
    send_frame(80, mc, 1, "R5 mcast hash");
    accept_en = 9'b0_0010_0010;
    send_frame(80, mc, 1, "R5 mcast via unicast hash");
    // bad CRC class (R7)
    accept_en = 9'b0_0100_1000;
    send_frame(70, station_addr, 0, "R7 bad crc");

    // random traffic
    for (int n = 0; n < 140; n++) begin
      accept_en  = 9'($urandom);
      accept_en[0] = (($urandom % 6) == 0);
      irq_en     = 4'($urandom);
      hash_table = {32'($urandom), 32'($urandom)};
      send_frame(pick_len(), pick_da(), (($urandom % 4) != 0), "rand");
      if (($urandom % 10) == 0) stray_bytes(2);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule